// File: doc/BRIEF.md
# Flash Command State Machine

This block is the command front end and status register of a parallel NOR-style flash device. The host issues single-cycle bus writes that carry a command byte and the block-select field of the address. The block decodes a two-write erase sequence, a two-write program sequence, erase suspend and resume, a program that runs while an erase is suspended, status clear, and read-mode selection. Erase and program run on abstract countdown engines whose lengths are set by parameters. The array is modelled only as one "erased" flag per block.

An 8-bit status word reports the result. Bit 7 is ready, bit 6 is erase-suspended, bit 5 is erase error, bit 4 is program or sequence error, bit 3 is low program voltage, bit 1 is locked block, and bits 2 and 0 read 0. A ready/busy output mirrors bit 7. Error bits are sticky: they build up over several operations until the host clears them. Two inputs gate every erase and program: a program-voltage-good flag and a per-block lock vector.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, status is 80h, sts_ready is 1, rd_status is 0 and every blk_erased flag is 0.
- R2: Writing 20h and then D0h to block b keeps status bit 7 at 0 for exactly ERASE_CYC cycles after the D0h write. When the erase completes, bit 7 returns to 1 and blk_erased[b] sets. rd_status stays 1 from the setup write onward.
- R3: After 20h, any second write other than D0h sets bits 5 and 4, starts no erase and leaves blk_erased unchanged.
- R4: An erase confirm while vpen_ok is 0 sets bits 5 and 3 and erases nothing.
- R5: An erase confirm to a block whose blk_lock bit is 1 sets bits 5 and 1 and erases nothing.
- R6: Command 50h clears bits 5, 4, 3 and 1 when the device is idle or erase-suspended. Nothing else clears them, so errors from successive operations accumulate.
- R7: Command 50h written while an erase or program is running leaves the error bits unchanged.
- R8: Command B0h written during an erase sets bit 6 and bit 7 on the next cycle and freezes the erase's remaining cycle count.
- R9: Writing 40h and then a data write to block b clears blk_erased[b] and holds bit 7 at 0 for PROG_CYC cycles. When this happens during an erase suspend, bit 6 stays 1 for the whole program.
- R10: D0h written during a program inside a suspend is ignored. D0h written after that program finishes clears bits 6 and 7, and the erase then completes after exactly its remaining cycles, so the unsuspended busy cycles total ERASE_CYC.
- R11: While suspended, any command outside read array (FFh), read status (70h), clear (50h), program setup (40h) and resume (D0h) leaves the status word unchanged.
- R12: A program is rejected and sets bit 4 in three cases: it targets the suspended erase's block; vpen_ok is 0 (which also sets bit 3); or the block is locked (which also sets bit 1).
- R13: Command FFh drives rd_status to 0 and 70h drives it to 1. sts_ready always equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_cmd | input | 8 | Command or data byte of the write |
| wr_blk | input | BLK_W | Block-select field of the write address |
| vpen_ok | input | 1 | Program voltage above lockout |
| blk_lock | input | NBLK | Lock bit per block |
| status | output | 8 | Status register |
| sts_ready | output | 1 | Ready (1) / busy (0) |
| rd_status | output | 1 | Reads return status (1) or array (0) |
| blk_erased | output | NBLK | Erased flag per block |

## Verification
Each write is captured on one rising edge, and status, sts_ready and rd_status all reflect it from that same edge. The bench therefore drives on falling edges and checks immediate results at the next falling edge. Busy lengths are measured by counting falling edges until bit 7 rises; the bench compares that count with ERASE_CYC or PROG_CYC, minus any edges consumed by writes issued during the busy window. For suspends placed at every possible offset into an erase, the post-resume busy count is checked against ERASE_CYC minus the offset minus one.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;

    localparam logic [7:0] OP_ERS_SETUP = 8'h20;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_SUSPEND   = 8'hB0;
    localparam logic [7:0] OP_RD_STAT   = 8'h70;
    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_PRG_SETUP = 8'h40;
    localparam logic [7:0] OP_CLR_STAT  = 8'h50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERS_SET,
        ST_PRG_SET,
        ST_ERASE,
        ST_PROG,
        ST_SUSP,
        ST_SUSP_PSET,
        ST_SUSP_PROG
    } fcsm_state_e;

    typedef struct packed {
        logic ers_fail;   // bit 5
        logic prg_fail;   // bit 4
        logic vpen_low;   // bit 3
        logic locked;     // bit 1
    } fcsm_err_t;

    function automatic logic [7:0] pack_status(input logic ready,
                                               input logic susp,
                                               input fcsm_err_t e);
        return {ready, susp, e.ers_fail, e.prg_fail, e.vpen_low, 1'b0, e.locked, 1'b0};
    endfunction

    function automatic logic is_suspended(input fcsm_state_e s);
        return (s == ST_SUSP) || (s == ST_SUSP_PSET) || (s == ST_SUSP_PROG);
    endfunction

    function automatic logic is_busy(input fcsm_state_e s);
        return (s == ST_ERASE) || (s == ST_PROG) || (s == ST_SUSP_PROG);
    endfunction

endpackage

// File: rtl/fcsm_engine.sv
module fcsm_engine #(
    parameter int CYC = 16,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic hold,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CYC);
        end else if (busy && !hold) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = busy && !hold && (cnt_q == CW'(1));

    // R8: a held engine keeps its remaining count
    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (hold && !start) |=> $stable(cnt_q));

    // R2: the count never exceeds its load value
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(CYC));

endmodule

// File: rtl/fcsm_blk_array.sv
module fcsm_blk_array #(
    parameter int NBLK = 4,
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [BLK_W-1:0] clr_idx,
    output logic [NBLK-1:0]  erased
);
    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                erased[i] <= 1'b0;
            end else if (set_en && (set_idx == BLK_W'(i))) begin
                erased[i] <= 1'b1;
            end else if (clr_en && (clr_idx == BLK_W'(i))) begin
                erased[i] <= 1'b0;
            end
        end
    end

    // R9: an erase completion and a program start never coincide
    a_r9_no_set_clr_same: assert property (@(posedge clk) disable iff (rst)
        !(set_en && clr_en));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import fcsm_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int ERASE_CYC = 64,
    parameter int PROG_CYC  = 16,
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_cmd,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             vpen_ok,
    input  logic [NBLK-1:0]  blk_lock,
    output logic [7:0]       status,
    output logic             sts_ready,
    output logic             rd_status,
    output logic [NBLK-1:0]  blk_erased
);
    fcsm_state_e      st_q, st_d;
    fcsm_err_t        err_q, err_d;
    logic             rds_q, rds_d;
    logic [BLK_W-1:0] eblk_q, eblk_d;

    logic ers_start, prg_start, ers_busy, ers_done, prg_busy, prg_done;
    logic arr_set, arr_clr, hold;
    logic prg_bad_vpen, prg_bad_lock, prg_bad_same, prg_bad;

    assign hold = is_suspended(st_q);

    fcsm_engine #(.CYC(ERASE_CYC)) i_ers_eng (
        .clk(clk), .rst(rst), .start(ers_start), .hold(hold),
        .busy(ers_busy), .done(ers_done)
    );

    fcsm_engine #(.CYC(PROG_CYC)) i_prg_eng (
        .clk(clk), .rst(rst), .start(prg_start), .hold(1'b0),
        .busy(prg_busy), .done(prg_done)
    );

    fcsm_blk_array #(.NBLK(NBLK)) i_arr (
        .clk(clk), .rst(rst),
        .set_en(arr_set), .set_idx(eblk_q),
        .clr_en(arr_clr), .clr_idx(wr_blk),
        .erased(blk_erased)
    );

    // program acceptance checks for the data write
    assign prg_bad_vpen = !vpen_ok;
    assign prg_bad_lock = blk_lock[wr_blk];
    assign prg_bad_same = (st_q == ST_SUSP_PSET) && (wr_blk == eblk_q);
    assign prg_bad      = prg_bad_vpen || prg_bad_lock || prg_bad_same;

    always_comb begin
        st_d      = st_q;
        err_d     = err_q;
        rds_d     = rds_q;
        eblk_d    = eblk_q;
        ers_start = 1'b0;
        prg_start = 1'b0;
        arr_set   = 1'b0;
        arr_clr   = 1'b0;
        unique case (st_q)
            ST_IDLE: if (wr_en) begin
                unique case (wr_cmd)
                    OP_ERS_SETUP: begin st_d = ST_ERS_SET; rds_d = 1'b1; end
                    OP_PRG_SETUP: begin st_d = ST_PRG_SET; rds_d = 1'b1; end
                    OP_CLR_STAT:  err_d = '0;
                    OP_RD_STAT:   rds_d = 1'b1;
                    OP_RD_ARRAY:  rds_d = 1'b0;
                    default: ;
                endcase
            end
            ST_ERS_SET: if (wr_en) begin
                rds_d = 1'b1;
                st_d  = ST_IDLE;
                if (wr_cmd != OP_CONFIRM) begin
                    err_d.ers_fail = 1'b1;
                    err_d.prg_fail = 1'b1;
                end else begin
                    if (!vpen_ok) begin
                        err_d.ers_fail = 1'b1;
                        err_d.vpen_low = 1'b1;
                    end
                    if (blk_lock[wr_blk]) begin
                        err_d.ers_fail = 1'b1;
                        err_d.locked   = 1'b1;
                    end
                    if (vpen_ok && !blk_lock[wr_blk]) begin
                        ers_start = 1'b1;
                        eblk_d    = wr_blk;
                        st_d      = ST_ERASE;
                    end
                end
            end
            ST_PRG_SET, ST_SUSP_PSET: if (wr_en) begin
                rds_d = 1'b1;
                if (prg_bad) begin
                    err_d.prg_fail = 1'b1;
                    if (prg_bad_vpen) err_d.vpen_low = 1'b1;
                    if (prg_bad_lock) err_d.locked   = 1'b1;
                    st_d = (st_q == ST_SUSP_PSET) ? ST_SUSP : ST_IDLE;
                end else begin
                    prg_start = 1'b1;
                    arr_clr   = 1'b1;
                    st_d = (st_q == ST_SUSP_PSET) ? ST_SUSP_PROG : ST_PROG;
                end
            end
            ST_ERASE: begin
                if (ers_done) begin
                    arr_set = 1'b1;
                    st_d    = ST_IDLE;
                end else if (wr_en && wr_cmd == OP_SUSPEND) begin
                    st_d  = ST_SUSP;
                    rds_d = 1'b1;
                end else if (wr_en && wr_cmd == OP_RD_STAT) begin
                    rds_d = 1'b1;
                end
            end
            ST_PROG, ST_SUSP_PROG: begin
                if (prg_done) begin
                    st_d = (st_q == ST_SUSP_PROG) ? ST_SUSP : ST_IDLE;
                end else if (wr_en && wr_cmd == OP_RD_STAT) begin
                    rds_d = 1'b1;
                end
            end
            ST_SUSP: if (wr_en) begin
                unique case (wr_cmd)
                    OP_RD_ARRAY:  rds_d = 1'b0;
                    OP_RD_STAT:   rds_d = 1'b1;
                    OP_CLR_STAT:  err_d = '0;
                    OP_PRG_SETUP: begin st_d = ST_SUSP_PSET; rds_d = 1'b1; end
                    OP_CONFIRM:   begin st_d = ST_ERASE;     rds_d = 1'b1; end
                    default: ;
                endcase
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            err_q  <= '0;
            rds_q  <= 1'b0;
            eblk_q <= '0;
        end else begin
            st_q   <= st_d;
            err_q  <= err_d;
            rds_q  <= rds_d;
            eblk_q <= eblk_d;
        end
    end

    assign status    = pack_status(!is_busy(st_q), hold, err_q);
    assign sts_ready = status[7];
    assign rd_status = rds_q;

    // R6: error bits fall only after a clear command
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(status[5]) |-> $past(wr_en && wr_cmd == OP_CLR_STAT));

    // R7: no clear while an engine runs
    a_r7_no_clear_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(status[4]) |-> $past(status[7]));

    // R8: suspension only follows a suspend command
    a_r8_susp_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(status[6]) |-> $past(wr_en && wr_cmd == OP_SUSPEND) && status[7]);

    // R10: leaving suspension only follows a resume command
    a_r10_resume_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(status[6]) |-> $past(wr_en && wr_cmd == OP_CONFIRM) && !status[7]);

    // R4: low program voltage always comes with an operation error
    a_r4_vpen_pair: assert property (@(posedge clk) disable iff (rst)
        $rose(status[3]) |-> (status[5] || status[4]));

    // R5: lock error always comes with an operation error
    a_r5_lock_pair: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> (status[5] || status[4]));

    // R2: an erased flag rises only as a busy period ends
    for (genvar i = 0; i < NBLK; i++) begin : g_chk
        a_r2_flag_at_end: assert property (@(posedge clk) disable iff (rst)
            $rose(blk_erased[i]) |-> $past(!status[7]) && status[7]);
    end

    // R9: the program engine runs only in a program state
    a_r9_prog_state: assert property (@(posedge clk) disable iff (rst)
        prg_busy |-> (st_q == ST_PROG || st_q == ST_SUSP_PROG));

    // R8: the erase engine is busy whenever erasing or suspended
    a_r8_ers_state: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ERASE || hold) |-> ers_busy);

endmodule

// File: tb/test_flash_cmd_fsm.sv
module test_flash_cmd_fsm;
    localparam int NB = 4;
    localparam int EC = 8;
    localparam int PC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_cmd = 8'h00;
    logic [1:0]    wr_blk = 2'd0;
    logic          vpen_ok = 1'b1;
    logic [NB-1:0] blk_lock = '0;
    logic [7:0]    status;
    logic          sts_ready, rd_status;
    logic [NB-1:0] blk_erased;

    int  n_run = 0, n_fail = 0;
    bit  finished = 0;
    logic [NB-1:0] exp_fl = '0;

    always #10 clk = ~clk;

    flash_cmd_fsm #(.NBLK(NB), .ERASE_CYC(EC), .PROG_CYC(PC)) i_flash_cmd_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_blk(wr_blk),
        .vpen_ok(vpen_ok), .blk_lock(blk_lock), .status(status),
        .sts_ready(sts_ready), .rd_status(rd_status), .blk_erased(blk_erased)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_st(input string req, input logic [7:0] exp);
        chk(status == exp, req, status, exp);
        chk(sts_ready == status[7], "R13", sts_ready, status[7]);
    endtask

    // called at a falling edge; one rising edge captures the write
    task automatic wr(input logic [7:0] c, input int b);
        wr_en = 1'b1; wr_cmd = c; wr_blk = 2'(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!status[7] && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic prog(input int b);
        int n;
        wr(8'h40, b);
        wr(8'h00, b);
        busy_len(n);
        chk(n == PC, "R9", n, PC);
        exp_fl[b] = 1'b0;
        chk(blk_erased == exp_fl, "R9", blk_erased, exp_fl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk_st("R1", 8'h80);
        chk(rd_status == 1'b0, "R1", rd_status, 0);
        chk(blk_erased == '0, "R1", blk_erased, 0);

        // R2: erase every block
        for (int b = 0; b < NB; b++) begin
            wr(8'h20, b);
            wr(8'hD0, b);
            chk_st("R2", 8'h00);
            busy_len(n);
            chk(n == EC, "R2", n, EC);
            exp_fl[b] = 1'b1;
            chk(blk_erased == exp_fl, "R2", blk_erased, exp_fl);
            chk(rd_status == 1'b1, "R2", rd_status, 1);
            chk_st("R2", 8'h80);
        end
        // R9: program every block
        for (int b = 0; b < NB; b++) prog(b);

        // R13: read modes
        wr(8'hFF, 0);
        chk(rd_status == 1'b0, "R13", rd_status, 0);
        wr(8'h70, 0);
        chk(rd_status == 1'b1, "R13", rd_status, 1);

        // R3: bad second write
        wr(8'h20, 1);
        wr(8'h70, 1);
        chk_st("R3", 8'hB0);
        chk(blk_erased == exp_fl, "R3", blk_erased, exp_fl);
        // R7: clear during erase has no effect
        wr(8'h20, 1);
        wr(8'hD0, 1);
        wr(8'h50, 1);
        chk_st("R7", 8'h30);
        busy_len(n);
        chk(n + 1 == EC, "R7", n + 1, EC);
        exp_fl[1] = 1'b1;
        chk_st("R7", 8'hB0);
        wr(8'h50, 0);
        chk_st("R6", 8'h80);

        // R4 then R5, accumulating (R6)
        vpen_ok = 1'b0;
        wr(8'h20, 0);
        wr(8'hD0, 0);
        chk_st("R4", 8'hA8);
        chk(blk_erased == exp_fl, "R4", blk_erased, exp_fl);
        vpen_ok = 1'b1;
        blk_lock = 4'b0100;
        wr(8'h20, 2);
        wr(8'hD0, 2);
        chk_st("R6", 8'hAA);
        chk(blk_erased == exp_fl, "R5", blk_erased, exp_fl);
        wr(8'h50, 0);
        chk_st("R6", 8'h80);
        blk_lock = '0;

        // R5: sweep lock patterns over every block
        for (int p = 0; p < 16; p++) begin
            for (int b = 0; b < NB; b++) begin
                blk_lock = '0;
                prog(b);
                blk_lock = 4'(p);
                wr(8'h20, b);
                wr(8'hD0, b);
                if (p[b]) begin
                    chk_st("R5", 8'hA2);
                    wr(8'h50, 0);
                end else begin
                    busy_len(n);
                    chk(n == EC, "R5", n, EC);
                    exp_fl[b] = 1'b1;
                end
                chk(blk_erased == exp_fl, "R5", blk_erased, exp_fl);
                chk_st("R5", 8'h80);
            end
        end
        blk_lock = '0;

        // R12: program with low voltage
        vpen_ok = 1'b0;
        wr(8'h40, 3);
        wr(8'h00, 3);
        chk_st("R12", 8'h98);
        vpen_ok = 1'b1;
        wr(8'h50, 0);

        // R8, R9, R10, R11, R12: suspend at each offset
        for (int s = 0; s <= EC - 2; s++) begin
            prog(0);
            wr(8'h20, 0);
            wr(8'hD0, 0);
            repeat (s) @(negedge clk);
            wr(8'hB0, 0);
            chk_st("R8", 8'hC0);
            repeat (3) @(negedge clk);
            chk_st("R8", 8'hC0);
            wr(8'h20, 1);
            chk_st("R11", 8'hC0);
            wr(8'h90, 1);
            chk_st("R11", 8'hC0);
            wr(8'h40, 0);
            wr(8'h00, 0);
            chk_st("R12", 8'hD0);
            wr(8'h50, 0);
            chk_st("R6", 8'hC0);
            wr(8'h40, 2);
            wr(8'h00, 2);
            exp_fl[2] = 1'b0;
            chk_st("R9", 8'h40);
            wr(8'hD0, 0);
            chk_st("R10", 8'h40);
            busy_len(n);
            chk(n + 1 == PC, "R9", n + 1, PC);
            chk_st("R10", 8'hC0);
            chk(blk_erased == exp_fl, "R9", blk_erased, exp_fl);
            wr(8'hD0, 0);
            chk_st("R10", 8'h00);
            busy_len(n);
            chk(n == EC - s - 1, "R10", n, EC - s - 1);
            exp_fl[0] = 1'b1;
            chk(blk_erased == exp_fl, "R10", blk_erased, exp_fl);
            chk_st("R10", 8'h80);
        end

        // R13: read array after all
        wr(8'hFF, 0);
        chk(rd_status == 1'b0, "R13", rd_status, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule